// File: doc/BRIEF.md
# Capture-Compare Timer Channel

This block is one timer channel for a bus peripheral. It holds a 32-bit up-counter that advances on ticks from a selectable source, either the bus clock directly, the bus clock divided by sixteen, or rising edges of an external input pin. An 8-bit prescaler sits between the source and the counter and divides by any value from 1 to 256. The same external pin, after a two-flop synchronizer, also drives an edge detector. On a chosen transition, that detector copies the current count into a capture register.

A reference register sets an event when the next counter tick would make the count equal to it. The counter then either restarts at zero or keeps running and wraps. A capture event always requests service. A reference event requests service only when its enable bit is set. One routing bit sends every pending request either to the interrupt output or to the DMA request output, and never to both. Software clears event flags by writing ones to the event register. A DMA acknowledge also clears them while DMA routing is selected.

Register word addresses on `addr`: 0 = mode, 1 = reference, 2 = capture (read only), 3 = counter, 4 = event. All other addresses read as zero.

Top module: `cc_timer`

## Requirements
- R1: After reset, the mode, reference, capture, counter and event registers read zero, and both `irq` and `dma_req` are low.
- R2: Mode bit 0 enables counting. Mode bits 15:8 hold the prescale value P. With source field bits 2:1 = 00, the counter advances once every P+1 enabled bus cycles. The first increment comes on the (P+1)-th enabled clock edge.
- R3: With source field = 01, the counter advances once every 16·(P+1) enabled bus cycles.
- R4: With source field = 10 or 11, the counter advances once per rising edge on `ext_in` (with P = 0). The count is unchanged two clock edges after the pin rises and has advanced after the third.
- R5: Any write to the counter address clears the count to zero, whatever the data. Reading the count does not change it.
- R6: While mode bit 0 is clear, the count holds its value. Clearing the bit also restarts the prescaler and divide-by-16 phase.
- R7: The capture edge field in mode bits 6:5 selects the trigger: 00 = none, 01 = rising, 10 = falling, 11 = both edges of the synchronized `ext_in`.
- R8: A capture trigger copies the current count into the capture register and sets event bit 0. Capture does not depend on mode bit 0.
- R9: When a tick would move the count to the reference value, event bit 1 is set. With mode bit 3 set, the count returns to zero instead. With mode bit 3 clear, the count takes the reference value and keeps counting.
- R10: A request is pending when event bit 0 is set, or when event bit 1 is set together with mode bit 4. When mode bit 7 is clear, a pending request drives `irq`. When mode bit 7 is set, it drives `dma_req`. The two outputs are never high together.
- R11: Writing a one to an event bit clears it. A `dma_ack` pulse clears both flags when mode bit 7 is set and is ignored when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| ext_in | input | 1 | External timer input pin (asynchronous) |
| dma_ack | input | 1 | DMA acknowledge, clears flags in DMA routing |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A register write takes effect at the clock edge that samples it. The first bus-clock tick therefore lands P+1 edges after the enable write (16·(P+1) for the divided source), and the bench computes the expected count after N edges as N/(P+1) or N/(16·(P+1)). A pin edge reaches the counter, the capture register and the flags on the third edge after it is driven. The bench reads the count after the second edge and again after the third, and reads captures and flags only after at least four edges. Flag and routing outputs follow the flags with no added register, so they are sampled at the falling edge after the setting event.

// File: rtl/cct_pkg.sv
// Package: shared constants and the mode-register layout of the timer channel.
// Assumes: a single channel; addresses are word indices on a 3-bit port.
package cct_pkg;
    localparam int PSC_W = 8;

    localparam logic [2:0] A_MODE  = 3'd0;
    localparam logic [2:0] A_REF   = 3'd1;
    localparam logic [2:0] A_CAPT  = 3'd2;
    localparam logic [2:0] A_COUNT = 3'd3;
    localparam logic [2:0] A_EVENT = 3'd4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    typedef struct packed {
        logic [PSC_W-1:0] psc;      // divide-minus-one
        logic             dma_en;   // route requests to DMA
        edge_sel_t        cap_edge; // capture trigger
        logic             ref_ie;   // reference event requests service
        logic             restart;  // zero on reference match
        logic [1:0]       src;      // 00 bus, 01 bus/16, 1x external
        logic             run;      // counting enable
    } mode_t;
endpackage

// File: rtl/cct_edge_sync.sv
// Module: synchronizes an asynchronous pin into the bus clock domain and
// flags rising and falling transitions of the synchronized value.
// Assumes: STAGES >= 2; edge pulses last one cycle.
module cct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain_q;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    // Compare the newest synchronized value with the one before it.
    always_comb begin
        rise = chain_q[STAGES-1] & ~chain_q[STAGES];
        fall = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/cct_tick_gen.sv
// Module: selects the count source and applies the programmable prescaler,
// producing one-cycle count ticks.
// Assumes: run gates everything; clr or !run restarts all dividers.
module cct_tick_gen #(
    parameter int PSC_W    = 8,
    parameter int DIV_SLOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [1:0]       src,
    input  logic [PSC_W-1:0] psc,
    input  logic             ext_rise,
    output logic             tick
);
    localparam int DIV_W = $clog2(DIV_SLOW);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_SLOW - 1);

    logic [DIV_W-1:0] div_q;
    logic [PSC_W-1:0] pc_q;
    logic             src_pulse;

    // Free-running slow divider, held in phase zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
    end

    // Pick the raw source pulse from the mode field.
    always_comb begin
        case (src)
            2'b00:   src_pulse = 1'b1;
            2'b01:   src_pulse = (div_q == DIV_LAST);
            default: src_pulse = ext_rise;
        endcase
    end

    // Prescaler counts source pulses and wraps after psc+1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || clr) pc_q <= '0;
        else if (src_pulse)        pc_q <= (pc_q == psc) ? '0 : pc_q + 1'b1;
    end

    // A tick is the source pulse that completes a prescale period.
    assign tick = run && !clr && src_pulse && (pc_q == psc);
endmodule

// File: rtl/cct_count_unit.sv
// Module: main up-counter with reference compare and restart option.
// Assumes: clr has priority over tick; match is judged on the next value.
module cct_count_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ref_hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next value and reference comparison on it.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        ref_hit = tick && (cnt_inc == ref_val);
    end

    // Count register: clear, restart on match, or advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt_q <= '0;
        else if (ref_hit && restart) cnt_q <= '0;
        else if (tick)              cnt_q <= cnt_inc;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cc_timer.sv
// Module: one capture-compare timer channel with a register port, capture
// from a synchronized pin, reference events, and interrupt/DMA routing.
// Assumes: writes commit on the clock edge; reads are combinational.
module cc_timer #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_SLOW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             ext_in,
    input  logic             dma_ack,
    output logic             irq,
    output logic             dma_req
);
    import cct_pkg::*;
    localparam int MODE_W = $bits(mode_t);

    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] capt_q;
    logic [CNT_W-1:0] cnt;
    logic             cap_f, ref_f;
    logic             ext_rise, ext_fall, tick, ref_hit, cap_hit;
    logic             cnt_clr, ev_wr, ack_clr, pending;

    assign cnt_clr = wr_en && (addr == A_COUNT);
    assign ev_wr   = wr_en && (addr == A_EVENT);
    assign ack_clr = dma_ack && mode_q.dma_en;

    cct_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(ext_in), .rise(ext_rise), .fall(ext_fall)
    );

    cct_tick_gen #(.PSC_W(PSC_W), .DIV_SLOW(DIV_SLOW)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(mode_q.run), .clr(cnt_clr),
        .src(mode_q.src), .psc(mode_q.psc), .ext_rise(ext_rise), .tick(tick)
    );

    cct_count_unit #(.CNT_W(CNT_W)) count_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
        .restart(mode_q.restart), .ref_val(ref_q), .cnt(cnt), .ref_hit(ref_hit)
    );

    // Decode the capture trigger from the selected edge type.
    always_comb begin
        case (mode_q.cap_edge)
            EDGE_RISE: cap_hit = ext_rise;
            EDGE_FALL: cap_hit = ext_fall;
            EDGE_BOTH: cap_hit = ext_rise | ext_fall;
            default:   cap_hit = 1'b0;
        endcase
    end

    // Mode and reference registers written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ref_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_MODE) mode_q <= mode_t'(wdata[MODE_W-1:0]);
            if (addr == A_REF)  ref_q  <= wdata;
        end
    end

    // Capture register latches the count on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)       capt_q <= '0;
        else if (cap_hit) capt_q <= cnt;
    end

    // Event flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_f <= 1'b0;
            ref_f <= 1'b0;
        end else begin
            if (cap_hit)                            cap_f <= 1'b1;
            else if ((ev_wr && wdata[0]) || ack_clr) cap_f <= 1'b0;
            if (ref_hit)                            ref_f <= 1'b1;
            else if ((ev_wr && wdata[1]) || ack_clr) ref_f <= 1'b0;
        end
    end

    // Route any pending request to exactly one output.
    always_comb begin
        pending = cap_f || (ref_f && mode_q.ref_ie);
        irq     = pending && !mode_q.dma_en;
        dma_req = pending && mode_q.dma_en;
    end

    // Combinational read mux.
    always_comb begin
        case (addr)
            A_MODE:  rdata = CNT_W'(mode_q);
            A_REF:   rdata = ref_q;
            A_CAPT:  rdata = capt_q;
            A_COUNT: rdata = cnt;
            A_EVENT: rdata = CNT_W'({ref_f, cap_f});
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_checker.sv
// Module: temporal checks on the timer channel, attached by bind.
// Assumes: signals are sampled on the bus clock; reset is synchronous.
module cct_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic             run,
    input logic [1:0]       cap_edge,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] capt,
    input logic             cap_f,
    input logic             ref_f,
    input logic             irq,
    input logic             dma_req
);
    logic clr_now;
    assign clr_now = wr_en && (addr == 3'd3);

    assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (cnt == '0));

    assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_now) |=> $stable(cnt));

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_now |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

    assert_no_capture_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_edge == 2'b00) |=> $stable(capt));

    assert_exclusive_routes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));

    assert_request_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_req) |-> (cap_f || ref_f));
endmodule

bind cc_timer cct_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .run(mode_q.run), .cap_edge(mode_q.cap_edge), .cnt(cnt), .capt(capt_q),
    .cap_f(cap_f), .ref_f(ref_f), .irq(irq), .dma_req(dma_req)
);

// File: tb/cc_timer_tb_top.sv
module cc_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_in = 1'b0;
    logic        dma_ack = 1'b0;
    logic        irq, dma_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] v;
    logic [31:0] c0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_in(ext_in), .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req)
    );

    function automatic logic [31:0] mk_mode(input logic run, input logic [1:0] src,
        input logic rst, input logic rie, input logic [1:0] edg, input logic dma,
        input logic [7:0] psc);
        return {16'd0, psc, dma, edg, rie, rst, src, run};
    endfunction

    function automatic logic [31:0] exp_cnt(input logic [1:0] src, input int p, input int n);
        return (src == 2'b00) ? 32'(n / (p + 1)) : 32'(n / (16 * (p + 1)));
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pin(input logic val);
        @(negedge clk);
        ext_in = val;
        edges(5);
    endtask

    initial begin : watchdog
        edges(190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4242));
        edges(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check("R1 register reset", v, 32'd0);
        end
        check("R1 irq reset", {31'd0, irq}, 32'd0);
        check("R1 dma_req reset", {31'd0, dma_req}, 32'd0);

        // R2/R3 constrained random prescale and source
        for (int i = 0; i < 8; i++) begin
            logic [1:0] s;
            int p, n;
            s = 2'($urandom % 2);
            p = int'($urandom % 4);
            n = int'($urandom % 300) + 1;
            wr(3'd0, 32'd0);
            wr(3'd3, 32'd0);
            wr(3'd0, mk_mode(1'b1, s, 1'b0, 1'b0, 2'b00, 1'b0, 8'(p)));
            edges(n);
            peek(3'd3, v);
            check(s == 2'b00 ? "R2 bus-clock prescale" : "R3 divided source", v, exp_cnt(s, p, n));
        end
        // directed corner: maximum prescale 256
        wr(3'd0, 32'd0); wr(3'd3, 32'd0);
        wr(3'd0, mk_mode(1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 8'hFF));
        edges(255); peek(3'd3, v); check("R2 divide-by-256 before tick", v, 32'd0);
        edges(1);   peek(3'd3, v); check("R2 divide-by-256 first tick", v, 32'd1);

        // R6 hold while stopped
        wr(3'd0, 32'd0);
        rd(3'd3, c0);
        edges(40);
        rd(3'd3, v); check("R6 stopped count holds", v, c0);
        check("R5 read does not disturb", v, c0);

        // R5 write clears regardless of data
        wr(3'd3, 32'hDEADBEEF);
        rd(3'd3, v); check("R5 write clears count", v, 32'd0);

        // R4 external source latency
        wr(3'd0, mk_mode(1'b1, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 8'd0));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            peek(3'd3, c0);
            ext_in = 1'b1;
            edges(2); @(negedge clk); peek(3'd3, v);
            check("R4 no advance after two edges", v, c0);
            edges(1); @(negedge clk); peek(3'd3, v);
            check("R4 advance after third edge", v, c0 + 32'd1);
            pin(1'b0);
        end

        // R8 capture latches count, independent of run
        wr(3'd0, 32'd0); wr(3'd3, 32'd0);
        wr(3'd0, mk_mode(1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 8'd0));
        edges(37);
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 8'd0));
        rd(3'd3, v); check("R8 stopped count", v, 32'd38);
        pin(1'b1);
        rd(3'd2, v); check("R8 capture value", v, 32'd38);
        rd(3'd4, v); check("R8 capture flag", v, 32'd1);
        check("R10 capture irq", {30'd0, dma_req, irq}, 32'd1);
        pin(1'b0);
        rd(3'd4, v); check("R7 rising mode ignores fall", v, 32'd1);
        wr(3'd4, 32'd1);
        rd(3'd4, v); check("R11 write-one clears capture flag", v, 32'd0);
        check("R10 irq drops with flag", {31'd0, irq}, 32'd0);

        // R7 falling, none, both
        wr(3'd3, 32'd0);
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 8'd0));
        pin(1'b1);
        rd(3'd4, v); check("R7 falling mode ignores rise", v, 32'd0);
        pin(1'b0);
        rd(3'd4, v); check("R7 falling mode captures", v, 32'd1);
        rd(3'd2, v); check("R7 falling capture value", v, 32'd0);
        wr(3'd4, 32'd1);
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 8'd0));
        pin(1'b1); pin(1'b0);
        rd(3'd4, v); check("R7 off mode no flag", v, 32'd0);
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b0, 2'b11, 1'b0, 8'd0));
        pin(1'b1);
        rd(3'd4, v); check("R7 both mode rise", v, 32'd1);
        wr(3'd4, 32'd1);
        pin(1'b0);
        rd(3'd4, v); check("R7 both mode fall", v, 32'd1);
        // R11 dma_ack ignored in interrupt routing
        @(negedge clk) dma_ack = 1'b1;
        @(negedge clk) dma_ack = 1'b0;
        rd(3'd4, v); check("R11 ack ignored without DMA", v, 32'd1);
        wr(3'd4, 32'd3);

        // R9 restart mode
        wr(3'd0, 32'd0); wr(3'd3, 32'd0); wr(3'd1, 32'd5);
        wr(3'd0, mk_mode(1'b1, 2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 8'd0));
        edges(4); @(negedge clk);
        peek(3'd3, v); check("R9 before match count", v, 32'd4);
        peek(3'd4, v); check("R9 before match flag", v, 32'd0);
        edges(1); @(negedge clk);
        peek(3'd3, v); check("R9 restart to zero", v, 32'd0);
        peek(3'd4, v); check("R9 reference flag", v, 32'd2);
        check("R10 reference irq", {30'd0, dma_req, irq}, 32'd1);
        edges(2); @(negedge clk);
        peek(3'd3, v); check("R9 restarted count", v, 32'd2);

        // R9 free-running mode
        wr(3'd0, 32'd0); wr(3'd4, 32'd2); wr(3'd3, 32'd0);
        wr(3'd0, mk_mode(1'b1, 2'b00, 1'b0, 1'b1, 2'b00, 1'b0, 8'd0));
        edges(5); @(negedge clk);
        peek(3'd3, v); check("R9 free count at match", v, 32'd5);
        peek(3'd4, v); check("R9 free flag", v, 32'd2);
        edges(2); @(negedge clk);
        peek(3'd3, v); check("R9 free continues", v, 32'd7);

        // R10/R11 routing
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 8'd0));
        @(negedge clk);
        check("R10 DMA routing", {30'd0, dma_req, irq}, 32'd2);
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 8'd0));
        @(negedge clk);
        check("R10 reference masked", {30'd0, dma_req, irq}, 32'd0);
        rd(3'd4, v); check("R10 masked flag kept", v, 32'd2);
        wr(3'd0, mk_mode(1'b0, 2'b00, 1'b0, 1'b1, 2'b00, 1'b1, 8'd0));
        @(negedge clk) dma_ack = 1'b1;
        @(negedge clk) dma_ack = 1'b0;
        rd(3'd4, v); check("R11 ack clears flags", v, 32'd0);
        check("R11 dma_req drops", {31'd0, dma_req}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule